// File: doc/BRIEF.md
# GPIO Input Conditioner

This block takes one asynchronous general-purpose input pin and turns it into clean, clock-domain signals. The pin is first brought into the clock domain by a short synchronizer chain. It then passes through three stages that always sit in the same order. The first is a glitch filter with a programmable length. The second is an event counter that can be bypassed. The last is an edge detector with separate rising and falling enables.

The filter and the counter can each be switched on or off independently. Together with the two edge polarities, these switches give a set of distinct conditioning functions. Each time the block is enabled, an auto-sense step captures the level the detector currently sees, so enabling the block never reports a false edge.

The outputs are:
- the conditioned level;
- a one-cycle event pulse from the counter;
- a sticky edge-status flag, cleared by a write-one-to-clear pulse.

Top module: `gpio_cond`

## Requirements
- R1: The pin passes through a two-flop synchronizer and one filter register and one stage register, so with the filter bypassed (or N=1) and the counter bypassed, a pin change reaches `level_o` on the fourth rising clock edge after it is applied.
- R2: With the filter on, a new level is passed only after the synchronized pin has held it for N consecutive samples (N = `flt_len_i`, 0 acts as 1); a pulse shorter than N samples never reaches `level_o`, and a level change appears N-1 edges later than with the filter bypassed.
- R3: With the counter on, it counts rising edges of the filtered level; when the count reaches `cnt_cmp_i` (0 acts as 1), `event_o` is high for exactly one cycle and the count returns to zero.
- R4: With the counter bypassed, `event_o` stays 0 and `level_o` is the filtered level.
- R5: With the counter on, `level_o` carries the event pulse, so the edge detector sees one rising edge per compare match.
- R6: `edge_sts_o` is set by a rising edge of `level_o` only when `rise_en_i` is 1, and by a falling edge only when `fall_en_i` is 1; with both 0 it is never set.
- R7: `edge_sts_o` stays set until a cycle with `clr_i` high and clears on the edge after that cycle.
- R8: Auto-sense: in the first cycle after `en_i` rises, the detector loads its previous-level register from `level_o` and reports no edge, even when the pin is already high.
- R9: While `en_i` is 0, the counter is held at zero, no event is produced, and `edge_sts_o` is not set.
- R10: After reset, `level_o`, `event_o` and `edge_sts_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous pin input |
| en_i | input | 1 | Block enable; a rising edge starts auto-sense |
| flt_en_i | input | 1 | Glitch filter on (1) or bypassed (0) |
| flt_len_i | input | FLT_W | Filter length N in samples |
| cnt_en_i | input | 1 | Event counter on (1) or bypassed (0) |
| cnt_cmp_i | input | CNT_W | Counter compare value |
| rise_en_i | input | 1 | Rising-edge detection enable |
| fall_en_i | input | 1 | Falling-edge detection enable |
| clr_i | input | 1 | Write-one-to-clear pulse for the status flag |
| level_o | output | 1 | Conditioned level |
| event_o | output | 1 | One-cycle counter match pulse |
| edge_sts_o | output | 1 | Sticky edge status |

## Verification
The bench uses the default widths: an 8-bit filter length and a 16-bit compare value. With these widths it drives filter lengths from 1 to 5 and compare values from 1 to 5. These values are enough to show glitches shorter than the filter length being rejected, and compare values the pulse count never reaches. Exact cycle latencies are checked for filter lengths 1 and 3. Auto-sense is checked with the pin already high before enable.

// File: rtl/gpio_cond_pkg.sv
package gpio_cond_pkg;
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic prev;
        logic armed;
        logic sts;
    } edge_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_filter.sv
module gpio_filter #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             flt_en,
    input  logic [LEN_W-1:0] len,
    output logic             dout
);
    typedef struct packed {
        logic             lvl;
        logic [LEN_W-1:0] run;
    } flt_t;

    flt_t             st_d, st_q;
    logic [LEN_W:0]   need;
    logic [LEN_W:0]   next_run;

    always_comb begin
        need     = (len == '0) ? (LEN_W+1)'(1) : {1'b0, len};
        next_run = {1'b0, st_q.run} + (LEN_W+1)'(1);
        st_d     = st_q;
        if (!flt_en) begin
            st_d.lvl = din;
            st_d.run = '0;
        end else if (din == st_q.lvl) begin
            st_d.run = '0;
        end else if (next_run >= need) begin
            st_d.lvl = din;
            st_d.run = '0;
        end else begin
            st_d.run = next_run[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.lvl;
endmodule

// File: rtl/gpio_evcount.sv
module gpio_evcount #(
    parameter int unsigned CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             en,
    input  logic             cnt_en,
    input  logic [CMP_W-1:0] cmp,
    output logic             ev_o,
    output logic             lvl_o
);
    typedef struct packed {
        logic             fd;
        logic             ev;
        logic [CMP_W-1:0] cnt;
    } cnt_t;

    cnt_t           st_d, st_q;
    logic [CMP_W:0] goal;
    logic [CMP_W:0] next_cnt;

    always_comb begin
        goal     = (cmp == '0) ? (CMP_W+1)'(1) : {1'b0, cmp};
        next_cnt = {1'b0, st_q.cnt} + (CMP_W+1)'(1);
        st_d     = st_q;
        st_d.fd  = din;
        st_d.ev  = 1'b0;
        if (!en || !cnt_en) begin
            st_d.cnt = '0;
        end else if (din && !st_q.fd) begin
            if (next_cnt >= goal) begin
                st_d.ev  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = next_cnt[CMP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_o  = st_q.ev;
    assign lvl_o = cnt_en ? st_q.ev : st_q.fd;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge
    import gpio_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic sts_o
);
    edge_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (!en) begin
            st_d.armed = 1'b0;
        end else if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.prev  = lvl;
        end else begin
            hit = (rise_en && lvl && !st_q.prev) ||
                  (fall_en && !lvl && st_q.prev);
            st_d.prev = lvl;
        end
        st_d.sts = (st_q.sts && !clr) || hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;
endmodule

// File: rtl/gpio_cond.sv
module gpio_cond
    import gpio_cond_pkg::*;
#(
    parameter int unsigned FLT_W = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             en_i,
    input  logic             flt_en_i,
    input  logic [FLT_W-1:0] flt_len_i,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] cnt_cmp_i,
    input  logic             rise_en_i,
    input  logic             fall_en_i,
    input  logic             clr_i,
    output logic             level_o,
    output logic             event_o,
    output logic             edge_sts_o
);
    logic pin_sync;
    logic pin_flt;
    logic stage_lvl;

    gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .din (pin_i), .dout (pin_sync)
    );

    gpio_filter #(.LEN_W(FLT_W)) u_filter (
        .clk (clk), .rst_n (rst_n), .din (pin_sync),
        .flt_en (flt_en_i), .len (flt_len_i), .dout (pin_flt)
    );

    gpio_evcount #(.CMP_W(CNT_W)) u_count (
        .clk (clk), .rst_n (rst_n), .din (pin_flt), .en (en_i),
        .cnt_en (cnt_en_i), .cmp (cnt_cmp_i),
        .ev_o (event_o), .lvl_o (stage_lvl)
    );

    gpio_edge u_edge (
        .clk (clk), .rst_n (rst_n), .lvl (stage_lvl), .en (en_i),
        .rise_en (rise_en_i), .fall_en (fall_en_i), .clr (clr_i),
        .sts_o (edge_sts_o)
    );

    assign level_o = stage_lvl;
endmodule

// File: rtl/gpio_cond_checker.sv
module gpio_cond_checker (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic cnt_en_i,
    input logic rise_en_i,
    input logic fall_en_i,
    input logic clr_i,
    input logic event_o,
    input logic edge_sts_o
);
    // R3: the match pulse lasts a single cycle
    a_r3_event_single: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);

    // R4: a bypassed counter produces no event
    a_r4_no_event_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_en_i) |-> !event_o);

    // R6: status can only rise when some polarity is enabled
    a_r6_needs_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_sts_o) |-> $past(rise_en_i || fall_en_i));

    // R7: status holds while no clear is requested
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        edge_sts_o && !clr_i |=> edge_sts_o);

    // R8: the cycle after enable rises never reports an edge
    a_r8_no_edge_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) && !$past(en_i, 2) |-> !$rose(edge_sts_o));

    // R9: disabled block sets no status
    a_r9_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_sts_o) |-> $past(en_i));
endmodule

bind gpio_cond gpio_cond_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .cnt_en_i   (cnt_en_i),
    .rise_en_i  (rise_en_i),
    .fall_en_i  (fall_en_i),
    .clr_i      (clr_i),
    .event_o    (event_o),
    .edge_sts_o (edge_sts_o)
);

// File: tb/gpio_cond_bench.sv
module gpio_cond_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       flt;
        logic       cnt;
        logic       rise;
        logic       fall;
        logic [7:0] len;
        logic [7:0] cmp;
        logic [3:0] pulses;
        logic [3:0] width;
        logic [3:0] exp_ev;
        logic       exp_sts;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 8'd1, 4'd3, 4'd2, 4'd0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd3, 8'd1, 4'd2, 4'd4, 4'd0, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd2, 8'd3, 4'd6, 4'd4, 4'd2, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 8'd2, 4'd4, 4'd2, 4'd2, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'd4, 8'd5, 4'd4, 4'd8, 4'd0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'd5, 8'd1, 4'd3, 4'd2, 4'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0, en = 1'b0, flt_en = 1'b0, cnt_en = 1'b0;
    logic        rise_en = 1'b0, fall_en = 1'b0, clr = 1'b0;
    logic [7:0]  flt_len = 8'd1;
    logic [15:0] cmp = 16'd1;
    logic        level, event_p, sts;
    int          checks = 0, errors = 0, ev_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_cond u_gpio_cond (
        .clk (clk), .rst_n (rst_n), .pin_i (pin), .en_i (en),
        .flt_en_i (flt_en), .flt_len_i (flt_len), .cnt_en_i (cnt_en),
        .cnt_cmp_i (cmp), .rise_en_i (rise_en), .fall_en_i (fall_en),
        .clr_i (clr), .level_o (level), .event_o (event_p),
        .edge_sts_o (sts)
    );

    always @(negedge clk) if (rst_n && event_p) ev_seen++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic f, input logic c, input logic r,
                           input logic fl, input logic [7:0] l,
                           input logic [15:0] m);
        rst_n = 1'b0; en = 1'b0; pin = 1'b0; clr = 1'b0;
        flt_en = f; cnt_en = c; rise_en = r; fall_en = fl;
        flt_len = l; cmp = m;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        en = 1'b1;
        cyc(4);
        ev_seen = 0;
    endtask

    task automatic pulses(input int n, input int w);
        for (int i = 0; i < n; i++) begin
            pin = 1'b1; cyc(w);
            pin = 1'b0; cyc(w);
        end
        cyc(12);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        cyc(2);
        check("R10 level", level, 0);
        check("R10 event", event_p, 0);
        check("R10 status", sts, 0);

        // Vector table: R2 R3 R4 R5 R6 across stage combinations
        for (int v = 0; v < NV; v++) begin
            restart(VECS[v].flt, VECS[v].cnt, VECS[v].rise, VECS[v].fall,
                    VECS[v].len, 16'(VECS[v].cmp));
            pulses(int'(VECS[v].pulses), int'(VECS[v].width));
            check($sformatf("R3/R4 vec%0d events", v), ev_seen, int'(VECS[v].exp_ev));
            check($sformatf("R2/R5/R6 vec%0d status", v), sts, int'(VECS[v].exp_sts));
        end

        // R1: latency with filter and counter bypassed
        restart(1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 16'd1);
        pin = 1'b1;
        cyc(3); check("R1 level before 4th edge", level, 0);
        cyc(1); check("R1 level at 4th edge", level, 1);
        check("R1 status not yet", sts, 0);
        cyc(1); check("R6 rising status", sts, 1);

        // R7: clear pulse
        clr = 1'b1; cyc(1); clr = 1'b0;
        cyc(1); check("R7 cleared", sts, 0);

        // R2: filter length 3 adds two edges of latency
        restart(1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 16'd1);
        pin = 1'b1;
        cyc(5); check("R2 level before N samples", level, 0);
        cyc(1); check("R2 level after N samples", level, 1);

        // R8: auto-sense with pin already high
        rst_n = 1'b0; en = 1'b0; cyc(2); rst_n = 1'b1;
        flt_en = 1'b0; cnt_en = 1'b0; rise_en = 1'b1; fall_en = 1'b1;
        pin = 1'b1; cyc(8);
        en = 1'b1; cyc(6);
        check("R8 no edge on enable", sts, 0);
        check("R8 level high", level, 1);
        pin = 1'b0; cyc(8);
        check("R8 falling edge after sense", sts, 1);

        // R9: disabled block counts nothing and sets nothing
        restart(1'b0, 1'b1, 1'b1, 1'b1, 8'd1, 16'd1);
        en = 1'b0;
        clr = 1'b1; cyc(1); clr = 1'b0;
        pulses(3, 3);
        check("R9 no events when disabled", ev_seen, 0);
        check("R9 no status when disabled", sts, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule